// File: doc/BRIEF.md
# Synchronous Serial Port Register and Queue Front-End

This block is the software-facing half of an SPI-style synchronous serial port. A host reaches it through a simple word-addressed bus with a single-cycle request and a registered read response. Behind the bus sit a transmit queue and a receive queue, each eight 16-bit words deep. A write to the data register pushes a word into the transmit queue. A read of the data register pops the oldest word from the receive queue. A separate transfer engine, outside this block, drains the transmit queue and fills the receive queue through a small take/put interface. The engine also reads the configuration fields that this block exports.

Status and raw interrupt flags are computed every cycle from the live occupancy of the two queues. The receive flag is raised when the receive queue is at least half full. The transmit flag is raised when the transmit queue is at most half full. One level-sensitive interrupt output goes high whenever any raw flag is enabled in the mask register. Overflowing data writes and data reads from an empty queue are absorbed without any effect. The top of the 4 KB space holds a fixed eight-word identification window.

The read path is a two-state access machine. `ACC_IDLE` waits for a request. A read request moves it to `ACC_RESP`, and also keeps it there when reads come back to back. In `ACC_RESP` the captured word is presented with `bus_rvalid` for one cycle, and the machine then returns to `ACC_IDLE` when no further read arrives. Writes never leave `ACC_IDLE`.

Top module: `ssp_frontend`

## Requirements
- R1: After reset both queues are empty, the mask reads 0, raw interrupt status reads 0x08, status reads 0x03, `irq` is low, `eng_tx_valid` is low and `eng_rx_space` is high.
- R2: Word index 0 holds a 16-bit frame/config word, index 1 holds a 4-bit control word, index 4 holds a prescaler that keeps bits [7:0], and index 5 holds a 4-bit mask. All of these read back what was written, truncated to their widths. Index 8 (DMA control) reads 0 and ignores writes. Any other undefined index reads 0, and writes to it have no effect.
- R3: Reads of word indices 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) return 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order.
- R4: Status (index 3) bit0 = transmit queue empty, bit1 = transmit queue not full, bit2 = receive queue not empty, bit3 = receive queue full, bit4 = transmit queue holds any entry (busy). All other bits are 0.
- R5: Raw interrupt status (index 6) bit2 = receive occupancy at least 4. Bit3 = transmit occupancy at most 4. All other bits are 0.
- R6: Masked status (index 7) reads raw AND mask, and `irq` is high exactly when that AND is non-zero.
- R7: A write to the data register (index 2) pushes the write data truncated to (config[3:0] + 1) bits. The push is discarded when the transmit queue already holds 8 entries.
- R8: A read of the data register pops and returns the oldest receive entry. With the receive queue empty, such a read returns 0 and changes no state.
- R9: An engine put stores `eng_rx_data` truncated to the frame size. `eng_rx_space` is low when the receive queue holds 8 entries, and a put is then ignored.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read request.
- R11: Both queues keep first-in first-out order across pointer wrap-around. Pointers advance modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| irq | output | 1 | Level interrupt |
| cfg_ctrl0 | output | 16 | Frame/config word for the engine |
| cfg_ctrl1 | output | 4 | Control word for the engine |
| cfg_prescale | output | 8 | Clock prescaler for the engine |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 16 | Oldest transmit entry |
| eng_tx_take | input | 1 | Engine removes the oldest transmit entry |
| eng_rx_space | output | 1 | Receive queue not full |
| eng_rx_put | input | 1 | Engine stores a received word |
| eng_rx_data | input | 16 | Received word |

## Verification
The embedded assertions watch every cycle for these properties: queue occupancy never exceeds eight, a push into a full queue or a pop from an empty one leaves occupancy unchanged, every read request is answered one cycle later, an empty data read returns zero, and `irq` stays low while the mask is zero. Only the bench scenarios can show that data values keep first-in first-out order through wrap-around, that truncation follows the configured frame size, and that the status and interrupt bits change at the exact threshold occupancies. Those scenarios also cover the identification bytes and the register readback values.

// File: rtl/ssp_fe_pkg.sv
package ssp_fe_pkg;
    localparam int ADDR_W = 10;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] IDX_CFG   = 10'h000;
    localparam logic [ADDR_W-1:0] IDX_CTL   = 10'h001;
    localparam logic [ADDR_W-1:0] IDX_DATA  = 10'h002;
    localparam logic [ADDR_W-1:0] IDX_STAT  = 10'h003;
    localparam logic [ADDR_W-1:0] IDX_PRE   = 10'h004;
    localparam logic [ADDR_W-1:0] IDX_MASK  = 10'h005;
    localparam logic [ADDR_W-1:0] IDX_RAW   = 10'h006;
    localparam logic [ADDR_W-1:0] IDX_MSKD  = 10'h007;
    localparam logic [ADDR_W-1:0] IDX_DMA   = 10'h008;
    localparam logic [ADDR_W-4:0] IDX_IDWIN = 7'h7F;

    typedef enum logic [0:0] {
        ACC_IDLE,
        ACC_RESP
    } acc_state_e;

    function automatic logic [7:0] id_byte(input logic [2:0] sel);
        unique case (sel)
            3'd0: id_byte = 8'h22;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/ssp_queue.sv
module ssp_queue #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head_data,
    output logic [$clog2(DEPTH):0]       count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_push   = push && (count != FULL_CNT);
    assign do_pop    = pop && (count != '0);
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push && !pop) |=> count == FULL_CNT);

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push) |=> count == '0);
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags #(
    parameter int DEPTH = 8
) (
    input  logic [$clog2(DEPTH):0] tx_count,
    input  logic [$clog2(DEPTH):0] rx_count,
    input  logic [3:0]             mask,
    output logic [4:0]             status,
    output logic [3:0]             raw,
    output logic [3:0]             masked,
    output logic                   irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    always_comb begin
        status    = '0;
        status[0] = (tx_count == '0);
        status[1] = (tx_count != FULL_CNT);
        status[2] = (rx_count != '0);
        status[3] = (rx_count == FULL_CNT);
        status[4] = (tx_count != '0);
        raw       = '0;
        raw[2]    = (rx_count >= HALF_CNT);
        raw[3]    = (tx_count <= HALF_CNT);
        masked    = raw & mask;
        irq       = |masked;
    end
endmodule

// File: rtl/ssp_frontend.sv
module ssp_frontend
    import ssp_fe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic [15:0]       cfg_ctrl0,
    output logic [3:0]        cfg_ctrl1,
    output logic [7:0]        cfg_prescale,
    output logic              eng_tx_valid,
    output logic [15:0]       eng_tx_data,
    input  logic              eng_tx_take,
    output logic              eng_rx_space,
    input  logic              eng_rx_put,
    input  logic [15:0]       eng_rx_data
);
    localparam int FSZ_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    acc_state_e       state, state_nx;
    logic             wr_acc, rd_acc;
    logic [DATA_W-1:0] frame_mask;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic [3:0]        mask_q;
    logic [4:0]        status;
    logic [3:0]        raw, masked;
    logic [BUS_W-1:0]  rd_val;

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            frame_mask[i] = (i <= int'(cfg_ctrl0[FSZ_W-1:0]));
    end

    ssp_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_acc && bus_addr == IDX_DATA),
        .push_data(bus_wdata[DATA_W-1:0] & frame_mask),
        .pop(eng_tx_take),
        .head_data(tx_head), .count(tx_count)
    );

    ssp_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_put),
        .push_data(eng_rx_data & frame_mask),
        .pop(rd_acc && bus_addr == IDX_DATA),
        .head_data(rx_head), .count(rx_count)
    );

    ssp_flags #(.DEPTH(DEPTH)) u_flags (
        .tx_count(tx_count), .rx_count(rx_count), .mask(mask_q),
        .status(status), .raw(raw), .masked(masked), .irq(irq)
    );

    assign eng_tx_valid = (tx_count != '0);
    assign eng_tx_data  = tx_head;
    assign eng_rx_space = (rx_count != CNT_W'(DEPTH));

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ctrl0    <= '0;
            cfg_ctrl1    <= '0;
            cfg_prescale <= '0;
            mask_q       <= '0;
        end else if (wr_acc) begin
            unique case (bus_addr)
                IDX_CFG:  cfg_ctrl0    <= bus_wdata[15:0];
                IDX_CTL:  cfg_ctrl1    <= bus_wdata[3:0];
                IDX_PRE:  cfg_prescale <= bus_wdata[7:0];
                IDX_MASK: mask_q       <= bus_wdata[3:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr[9:3] == IDX_IDWIN) begin
            rd_val[7:0] = id_byte(bus_addr[2:0]);
        end else begin
            unique case (bus_addr)
                IDX_CFG:  rd_val[15:0]     = cfg_ctrl0;
                IDX_CTL:  rd_val[3:0]      = cfg_ctrl1;
                IDX_DATA: rd_val[DATA_W-1:0] = (rx_count != '0) ? rx_head : '0;
                IDX_STAT: rd_val[4:0]      = status;
                IDX_PRE:  rd_val[7:0]      = cfg_prescale;
                IDX_MASK: rd_val[3:0]      = mask_q;
                IDX_RAW:  rd_val[3:0]      = raw;
                IDX_MSKD: rd_val[3:0]      = masked;
                default:  rd_val = '0;
            endcase
        end
    end

    // access state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ACC_IDLE: state_nx = rd_acc ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_nx = rd_acc ? ACC_RESP : ACC_IDLE;
            default:  state_nx = ACC_IDLE;
        endcase
    end

    // access state machine: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_acc ? rd_val : '0;
    end
    assign bus_rvalid = (state == ACC_RESP);

    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);

    // R8
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr == IDX_DATA && rx_count == '0) |=> bus_rdata == '0);

    // R6
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

// File: tb/tb_ssp_frontend.sv
`timescale 1ns/1ps
module tb_ssp_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq;
    logic [15:0] cfg_ctrl0;
    logic [3:0]  cfg_ctrl1;
    logic [7:0]  cfg_prescale;
    logic        eng_tx_valid, eng_rx_space;
    logic [15:0] eng_tx_data;
    logic        eng_tx_take = 1'b0, eng_rx_put = 1'b0;
    logic [15:0] eng_rx_data = '0;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ssp_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .cfg_ctrl0(cfg_ctrl0),
        .cfg_ctrl1(cfg_ctrl1), .cfg_prescale(cfg_prescale),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_take(eng_tx_take), .eng_rx_space(eng_rx_space),
        .eng_rx_put(eng_rx_put), .eng_rx_data(eng_rx_data)
    );

    // {is_read, byte offset, write data, expected read}
    localparam int NV = 26;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0000_0007, 32'h0},
        {1'b1, 12'h000, 32'h0,         32'h0000_0007},
        {1'b0, 12'h004, 32'h0000_00FF, 32'h0},
        {1'b1, 12'h004, 32'h0,         32'h0000_000F},
        {1'b0, 12'h010, 32'h0000_1234, 32'h0},
        {1'b1, 12'h010, 32'h0,         32'h0000_0034},
        {1'b0, 12'h014, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 12'h014, 32'h0,         32'h0000_000F},
        {1'b1, 12'h018, 32'h0,         32'h0000_0008},
        {1'b1, 12'h01C, 32'h0,         32'h0000_0008},
        {1'b0, 12'h020, 32'h0000_FFFF, 32'h0},
        {1'b1, 12'h020, 32'h0,         32'h0},
        {1'b0, 12'h024, 32'h0000_0005, 32'h0},
        {1'b1, 12'h024, 32'h0,         32'h0},
        {1'b1, 12'h800, 32'h0,         32'h0},
        {1'b1, 12'hFE0, 32'h0,         32'h22},
        {1'b1, 12'hFE4, 32'h0,         32'h10},
        {1'b1, 12'hFE8, 32'h0,         32'h04},
        {1'b1, 12'hFEC, 32'h0,         32'h00},
        {1'b1, 12'hFF0, 32'h0,         32'h0D},
        {1'b1, 12'hFF4, 32'h0,         32'hF0},
        {1'b1, 12'hFF8, 32'h0,         32'h05},
        {1'b1, 12'hFFC, 32'h0,         32'hB1},
        {1'b0, 12'h014, 32'h0,         32'h0},
        {1'b1, 12'h01C, 32'h0,         32'h0},
        {1'b1, 12'h00C, 32'h0,         32'h0000_0003}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ofs[11:2]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] ofs, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ofs[11:2];
        @(negedge clk);
        bus_sel = 1'b0;
        check("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic eng_step(input logic take, input logic put, input logic [15:0] pd);
        @(negedge clk);
        eng_tx_take = take; eng_rx_put = put; eng_rx_data = pd;
        @(negedge clk);
        eng_tx_take = 1'b0; eng_rx_put = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] echo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 tx_valid", {31'b0, eng_tx_valid}, 32'h0);
        check("R1 rx_space", {31'b0, eng_rx_space}, 32'h1);
        check("R10 idle rvalid", {31'b0, bus_rvalid}, 32'h0);
        bus_read(12'h00C, rd); check("R1 status", rd, 32'h03);
        bus_read(12'h018, rd); check("R1 raw", rd, 32'h08);
        bus_read(12'h014, rd); check("R1 mask", rd, 32'h0);

        // R2 / R3 register and ID vectors
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][76]) begin
                bus_read(VEC[v][75:64], rd);
                check(VEC[v][75:64] >= 12'hFE0 ? "R3 id" : "R2 reg", rd, VEC[v][31:0]);
            end else begin
                bus_write(VEC[v][75:64], VEC[v][63:32]);
            end
        end
        check("R2 cfg out", {16'b0, cfg_ctrl0}, 32'h7);
        check("R2 presc out", {24'b0, cfg_prescale}, 32'h34);

        // R7 fill, truncation to 8 bits, full discard
        for (int i = 0; i < 8; i++) bus_write(12'h008, 32'h1F0 + i);
        bus_write(12'h008, 32'h1EE);
        bus_read(12'h00C, rd); check("R4 status tx full", rd, 32'h10);
        bus_read(12'h018, rd); check("R5 raw tx 8", rd, 32'h00);
        for (int i = 0; i < 9; i++) begin
            if (i < 8) begin
                check("R7 tx order", {16'b0, eng_tx_data}, 32'hF0 + i);
                check("R7 tx valid", {31'b0, eng_tx_valid}, 32'h1);
                echo = eng_tx_data | 16'hFF00;
                eng_step(1'b1, 1'b1, echo);
            end else begin
                check("R7 overflow dropped", {31'b0, eng_tx_valid}, 32'h0);
            end
        end
        bus_read(12'h00C, rd); check("R4 status rx full", rd, 32'h0F);
        bus_read(12'h018, rd); check("R5 raw both", rd, 32'h0C);
        check("R9 rx space low", {31'b0, eng_rx_space}, 32'h0);
        eng_step(1'b0, 1'b1, 16'h0077);

        // R6 irq and masked status
        check("R6 irq masked off", {31'b0, irq}, 32'h0);
        bus_write(12'h014, 32'h4);
        check("R6 irq on", {31'b0, irq}, 32'h1);
        bus_read(12'h01C, rd); check("R6 masked", rd, 32'h04);

        // R8 pop order, R9 truncation, R5 rx threshold
        for (int i = 0; i < 8; i++) begin
            bus_read(12'h008, rd);
            check("R8 rx data", rd, 32'hF0 + i);
            check("R5 irq rx threshold", {31'b0, irq}, ((7 - i) >= 4) ? 32'h1 : 32'h0);
        end
        bus_read(12'h008, rd); check("R8 empty read", rd, 32'h0);
        bus_read(12'h00C, rd); check("R8 status unchanged", rd, 32'h03);

        // R7 / R9 with 4-bit frames
        bus_write(12'h000, 32'h3);
        bus_write(12'h008, 32'hFF);
        check("R7 4-bit frame", {16'b0, eng_tx_data}, 32'hF);
        eng_step(1'b1, 1'b1, 16'h0ABC);
        bus_read(12'h008, rd); check("R9 rx 4-bit frame", rd, 32'hC);

        // R11 wrap with 16-bit frames
        bus_write(12'h000, 32'hF);
        for (int i = 0; i < 8; i++) bus_write(12'h008, 32'h1000 + 32'(i * 257));
        for (int i = 0; i < 8; i++) begin
            check("R11 tx wrap", {16'b0, eng_tx_data}, 32'h1000 + 32'(i * 257));
            echo = eng_tx_data;
            eng_step(1'b1, 1'b1, echo);
        end
        for (int i = 0; i < 8; i++) begin
            bus_read(12'h008, rd);
            check("R11 rx wrap", rd, 32'h1000 + 32'(i * 257));
        end

        // R5 / R6 transmit threshold interrupt
        bus_write(12'h014, 32'h8);
        check("R6 irq tx flag", {31'b0, irq}, 32'h1);
        bus_read(12'h01C, rd); check("R6 masked tx", rd, 32'h08);
        for (int i = 0; i < 5; i++) bus_write(12'h008, 32'h1);
        check("R5 irq tx 5 entries", {31'b0, irq}, 32'h0);
        eng_step(1'b1, 1'b0, 16'h0);
        check("R5 irq tx 4 entries", {31'b0, irq}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule